// File: doc/BRIEF.md
# Burst Bus Wait-State Sequencer

This block runs the data phases of a processor-side external bus master. A request names a direction, a burst length of one to four transfers and a memory region. The sequencer issues an address strobe, counts out the wait states programmed for that region, produces one data transfer per beat, and raises a done pulse when the access is over. It also drives the direction and enable signals for the data transceivers.

Each of four regions holds its own set of wait counts. There is one count each for the first and later read beats, one each for the first and later write beats, and one for a gap after the access before the next address may go out. Each region also has enables for the external ready handshake and for burst termination, and a flag that marks it as pipelined. With ready enabled, a slow target can stretch any data beat past its programmed count. With burst termination enabled, the target can break a burst into fresh address cycles. The gap after an access can never be stretched.

The bus control pins are active-low and driven from registers, with one exception: the direction pin is high when the master receives data. The reset is synchronous and active-high.

Top module: `burst_wait_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `ads_n`, `wait_n`, `blast_n` and `den_n` are high, `done` and `dt_r` are low, and `req_ready` is high.
- R2: `cfg_word` is laid out as first-read wait [17:15], later-read wait [14:12], first-write wait [11:9], later-write wait [8:6], post-access gap [5:3], ready enable [2], terminate enable [1], pipelined [0]. A write through `cfg_wr` updates region `cfg_region` only while the sequencer is idle, and a write attempted during an access has no effect on that access or on later ones.
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, with `req_len` equal to the beat count minus one. The next cycle is a single address cycle with `ads_n` low. It is followed by the first-beat wait count of internal wait cycles and then a data cycle. Each later beat in the same address cycle uses the later-beat wait count.
- R4: When the region's ready enable is set, `ready_n` is examined only once a beat's wait count has run out, and each cycle in which it is high adds one more wait cycle. When the enable is clear, `ready_n` has no effect.
- R5: When the region has both ready and terminate enabled and `bterm_n` is low at a beat's sample point, that beat completes whatever `ready_n` shows. If beats remain, the next cycle is a new address cycle and the next beat uses the first-beat wait count. With terminate disabled, `bterm_n` has no effect.
- R6: `wait_n` is low only in data-phase wait cycles produced by the counter. It stays high during cycles stretched by `ready_n`, during address cycles and during the gap.
- R7: `blast_n` is low in the last beat of every access, from the cycle the counter reaches zero through the cycle that completes the beat, and it is high in all other cycles.
- R8: `den_n` is low from the first data-phase cycle through the final data cycle, including all wait cycles in between, and it is high during a non-pipelined address cycle and when idle.
- R9: `dt_r` is high for reads and low for writes, takes its value from the address cycle onward, and changes only when `den_n` is high both before and after the change.
- R10: After the final data cycle, the gap count in cycles passes with `req_ready` low and `ads_n` high, and neither `ready_n` nor `bterm_n` can change its length.
- R11: `done` is high for exactly one cycle, the cycle after the final data cycle of an access.
- R12: In a pipelined region with a zero gap, a read's final data cycle raises `req_ready` for a read request to a pipelined region. If that request is accepted, the next address cycle follows immediately and `den_n` stays low across it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active-high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_region | input | 2 | Region that the configuration write targets |
| cfg_word | input | 18 | Region configuration word (layout in R2) |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_len | input | 2 | Beat count minus one |
| req_region | input | 2 | Region of the access |
| ready_n | input | 1 | External ready, active-low |
| bterm_n | input | 1 | External burst terminate, active-low |
| ads_n | output | 1 | Address strobe, active-low |
| wait_n | output | 1 | Internal wait-state indicator, active-low |
| blast_n | output | 1 | Last-transfer indicator, active-low |
| den_n | output | 1 | Data transceiver enable, active-low |
| dt_r | output | 1 | Transceiver direction, high = receive |
| done | output | 1 | One-cycle access-complete pulse |

## Verification
Several pin relations are checked on every clock cycle:
- a wait cycle always falls inside the data enable window;
- last-transfer never overlaps an internal wait;
- the direction pin moves only while data enable is inactive;
- address strobes and done pulses never last two cycles;
- the wait and gap counters step down by exactly one.

The exact cycle placement of each phase can only be shown by the bench scenarios. These cover a beat stretched by ready, a burst split by terminate, terminate and ready being ignored where their region disables them, the exact gap length, held data enable across pipelined reads, and a configuration write discarded mid-access.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
    parameter int WAIT_W = 3;
    parameter int NREG   = 4;
    parameter int LEN_W  = 2;
    localparam int REG_W = $clog2(NREG);
    localparam logic [WAIT_W-1:0] WONE = 1;

    typedef struct packed {
        logic [WAIT_W-1:0] rd_first;
        logic [WAIT_W-1:0] rd_next;
        logic [WAIT_W-1:0] wr_first;
        logic [WAIT_W-1:0] wr_next;
        logic [WAIT_W-1:0] addr_gap;
        logic              rdy_en;
        logic              bt_en;
        logic              pipe;
    } region_cfg_t;

    localparam int CFG_W = $bits(region_cfg_t);

    typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_GAP} seq_state_t;

    typedef struct packed {
        logic ads;
        logic wait_s;
        logic blast;
        logic den;
        logic dtr;
        logic done;
    } bus_ctl_t;

    function automatic logic [WAIT_W-1:0] first_wait(region_cfg_t c, logic wr);
        return wr ? c.wr_first : c.rd_first;
    endfunction

    function automatic logic [WAIT_W-1:0] next_wait(region_cfg_t c, logic wr);
        return wr ? c.wr_next : c.rd_next;
    endfunction
endpackage

// File: rtl/bseq_cfg_bank.sv
module bseq_cfg_bank
    import bseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_idx,
    input  region_cfg_t          wr_data,
    input  logic [REG_W-1:0]     rd_idx_a,
    input  logic [REG_W-1:0]     rd_idx_b,
    output region_cfg_t          cfg_a,
    output region_cfg_t          cfg_b
);
    region_cfg_t bank [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_region
        region_cfg_t slot_q;
        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= '0;
            else if (wr_en && wr_idx == REG_W'(g))
                slot_q <= wr_data;
        end
        assign bank[g] = slot_q;
    end

    assign cfg_a = bank[rd_idx_a];
    assign cfg_b = bank[rd_idx_b];
endmodule

// File: rtl/bseq_core.sv
module bseq_core
    import bseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [LEN_W-1:0] req_len,
    input  logic [REG_W-1:0] req_region,
    input  region_cfg_t      cfg_cur,
    input  region_cfg_t      cfg_req,
    input  logic             ready_s,
    input  logic             bterm_s,
    output logic             req_ready,
    output logic             idle,
    output logic [REG_W-1:0] cur_region,
    output bus_ctl_t         ctl_nx
);
    seq_state_t        state_q, state_d;
    logic [WAIT_W-1:0] cnt_q, cnt_d;
    logic [LEN_W-1:0]  left_q, left_d;
    logic              wr_q, wr_d;
    logic              hold_q, hold_d;
    logic [REG_W-1:0]  reg_q, reg_d;

    logic sample, use_bt, bt_hit, xfer, last, fin, pipe_ok, accept;

    always_comb begin
        sample    = (state_q == ST_DATA) && (cnt_q == '0);
        use_bt    = cfg_cur.rdy_en && cfg_cur.bt_en;
        bt_hit    = sample && use_bt && bterm_s;
        xfer      = sample && (bt_hit || !cfg_cur.rdy_en || ready_s);
        last      = (left_q == '0);
        fin       = xfer && last;
        pipe_ok   = fin && !wr_q && cfg_cur.pipe && (cfg_cur.addr_gap == '0)
                    && !req_write && cfg_req.pipe;
        req_ready = (state_q == ST_IDLE) || pipe_ok;
        accept    = req_valid && req_ready;
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        left_d  = left_q;
        wr_d    = wr_q;
        hold_d  = hold_q;
        reg_d   = reg_q;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                state_d = ST_ADDR;
                wr_d    = req_write;
                left_d  = req_len;
                reg_d   = req_region;
                hold_d  = 1'b0;
            end
            ST_ADDR: begin
                state_d = ST_DATA;
                cnt_d   = first_wait(cfg_cur, wr_q);
                hold_d  = 1'b0;
            end
            ST_DATA: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - WONE;
                end else if (xfer) begin
                    if (last) begin
                        if (accept) begin
                            state_d = ST_ADDR;
                            wr_d    = req_write;
                            left_d  = req_len;
                            reg_d   = req_region;
                            hold_d  = 1'b1;
                        end else if (cfg_cur.addr_gap != '0) begin
                            state_d = ST_GAP;
                            cnt_d   = cfg_cur.addr_gap;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end else if (bt_hit) begin
                        state_d = ST_ADDR;
                        left_d  = left_q - 1'b1;
                    end else begin
                        cnt_d  = next_wait(cfg_cur, wr_q);
                        left_d = left_q - 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (cnt_q > WONE) cnt_d = cnt_q - WONE;
                else              state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl_nx.ads    = (state_d == ST_ADDR);
        ctl_nx.den    = (state_d == ST_DATA) || ((state_d == ST_ADDR) && hold_d);
        ctl_nx.wait_s = (state_d == ST_DATA) && (cnt_d != '0);
        ctl_nx.blast  = (state_d == ST_DATA) && (cnt_d == '0) && (left_d == '0);
        ctl_nx.dtr    = !wr_d;
        ctl_nx.done   = fin;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            left_q  <= '0;
            wr_q    <= 1'b1;
            hold_q  <= 1'b0;
            reg_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            left_q  <= left_d;
            wr_q    <= wr_d;
            hold_q  <= hold_d;
            reg_q   <= reg_d;
        end
    end

    assign idle       = (state_q == ST_IDLE);
    assign cur_region = reg_q;

    // Internal wait counter steps down by one per cycle inside a beat (R3)
    assert_wait_step_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA && cnt_q != '0) |=> (state_q == ST_DATA && cnt_q == $past(cnt_q) - WONE));

    // Gap runs its count exactly, regardless of READY/BTERM (R10)
    assert_gap_step_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GAP && cnt_q > WONE) |=> (state_q == ST_GAP && cnt_q == $past(cnt_q) - WONE));

    // A terminated beat with beats remaining re-enters an address cycle (R5)
    assert_bterm_readdr_R5: assert property (@(posedge clk) disable iff (rst)
        (sample && use_bt && bterm_s && left_q != '0) |=> (state_q == ST_ADDR));
endmodule

// File: rtl/burst_wait_seq.sv
module burst_wait_seq
    import bseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_region,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [LEN_W-1:0] req_len,
    input  logic [REG_W-1:0] req_region,
    input  logic             ready_n,
    input  logic             bterm_n,
    output logic             ads_n,
    output logic             wait_n,
    output logic             blast_n,
    output logic             den_n,
    output logic             dt_r,
    output logic             done
);
    region_cfg_t      cfg_cur, cfg_req;
    logic             idle;
    logic [REG_W-1:0] cur_region;
    bus_ctl_t         ctl_nx;

    bseq_cfg_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr && idle),
        .wr_idx   (cfg_region),
        .wr_data  (region_cfg_t'(cfg_word)),
        .rd_idx_a (cur_region),
        .rd_idx_b (req_region),
        .cfg_a    (cfg_cur),
        .cfg_b    (cfg_req)
    );

    bseq_core u_core (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_len    (req_len),
        .req_region (req_region),
        .cfg_cur    (cfg_cur),
        .cfg_req    (cfg_req),
        .ready_s    (!ready_n),
        .bterm_s    (!bterm_n),
        .req_ready  (req_ready),
        .idle       (idle),
        .cur_region (cur_region),
        .ctl_nx     (ctl_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ads_n   <= 1'b1;
            wait_n  <= 1'b1;
            blast_n <= 1'b1;
            den_n   <= 1'b1;
            dt_r    <= 1'b0;
            done    <= 1'b0;
        end else begin
            ads_n   <= !ctl_nx.ads;
            wait_n  <= !ctl_nx.wait_s;
            blast_n <= !ctl_nx.blast;
            den_n   <= !ctl_nx.den;
            dt_r    <= ctl_nx.dtr;
            done    <= ctl_nx.done;
        end
    end

    assert_wait_in_den_R6: assert property (@(posedge clk) disable iff (rst)
        !wait_n |-> !den_n);

    assert_blast_no_wait_R7: assert property (@(posedge clk) disable iff (rst)
        !blast_n |-> wait_n);

    assert_dtr_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (dt_r != $past(dt_r)) |-> (den_n && $past(den_n)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_ads_single_R3: assert property (@(posedge clk) disable iff (rst)
        !ads_n |=> ads_n);
endmodule

// File: tb/test_burst_wait_seq.sv
module test_burst_wait_seq;
    import bseq_pkg::*;

    logic clk = 0;
    logic rst = 1;
    logic cfg_wr = 0;
    logic [REG_W-1:0] cfg_region = '0;
    logic [CFG_W-1:0] cfg_word = '0;
    logic req_valid = 0;
    logic req_ready;
    logic req_write = 0;
    logic [LEN_W-1:0] req_len = '0;
    logic [REG_W-1:0] req_region = '0;
    logic ready_n = 1;
    logic bterm_n = 1;
    logic ads_n, wait_n, blast_n, den_n, dt_r, done;

    always #5 clk = ~clk;

    burst_wait_seq i_burst_wait_seq (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_region(cfg_region), .cfg_word(cfg_word),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_len(req_len),
        .req_region(req_region), .ready_n(ready_n), .bterm_n(bterm_n),
        .ads_n(ads_n), .wait_n(wait_n), .blast_n(blast_n), .den_n(den_n), .dt_r(dt_r), .done(done)
    );

    int rf [4] = '{2, 0, 1, 1};
    int rn [4] = '{1, 0, 2, 0};
    int wf [4] = '{1, 3, 0, 0};
    int wn [4] = '{0, 2, 1, 0};
    int gp [4] = '{1, 0, 2, 0};
    int re [4] = '{1, 0, 1, 0};
    int be [4] = '{1, 0, 0, 0};
    int pp [4] = '{0, 0, 0, 1};

    int checks = 0;
    int fails  = 0;
    int mism;
    string m_what;
    bit m_act, m_exp;
    bit exp_dtr;

    function automatic logic [CFG_W-1:0] mkcfg(int a, int b, int c, int d, int e, int f, int g, int h);
        return {3'(a), 3'(b), 3'(c), 3'(d), 3'(e), 1'(f), 1'(g), 1'(h)};
    endfunction

    task automatic cmp(input logic act, input bit exp, input string what);
        if (act !== exp) begin
            if (mism == 0) begin m_what = what; m_act = act; m_exp = exp; end
            mism++;
        end
    endtask

    // Drive inputs for this cycle, compare the outputs of this cycle, move to next cycle.
    task automatic step(input bit ea, ew, eb, ed, eo, er, input bit ri, bi);
        ready_n = !ri;
        bterm_n = !bi;
        cmp(!ads_n,   ea, "R3 ads");
        cmp(!wait_n,  ew, "R6 wait");
        cmp(!blast_n, eb, "R7 blast");
        cmp(!den_n,   ed, "R8 den");
        cmp(dt_r,     exp_dtr, "R9 dt_r");
        cmp(done,     eo, "R11 done");
        cmp(req_ready, er, "R10 req_ready");
        @(negedge clk);
    endtask

    task automatic finish_check(input string name);
        checks++;
        if (mism != 0) begin
            fails++;
            $display("FAIL %s: first mismatch %s actual=%0d expected=%0d (%0d mismatching samples)",
                     name, m_what, m_act, m_exp, mism);
        end
    endtask

    // Expected trace computed from R3..R11 for one access.
    task automatic run_txn(input int r, input bit wr, input int len, input bit poke, input string name);
        bit bt_prev = 0;
        mism = 0;
        cmp(req_ready, 1'b1, "R3 idle ready");
        req_valid = 1; req_write = wr; req_len = LEN_W'(len - 1); req_region = REG_W'(r);
        @(negedge clk);
        req_valid = 0;
        exp_dtr = !wr;
        for (int b = 0; b < len; b++) begin
            bit first = (b == 0) || bt_prev;
            bit lastb = (b == len - 1);
            int nw = first ? (wr ? wf[r] : rf[r]) : (wr ? wn[r] : rn[r]);
            bit bt_try = ((b + wr + len) % 2) == 1;
            bit bt_eff = bt_try && re[r] == 1 && be[r] == 1;
            int stalls = (re[r] == 1 && !bt_eff) ? (b + len + wr) % 3 : 0;
            if (first) begin
                if (poke) begin
                    cfg_wr = 1; cfg_region = REG_W'(r); cfg_word = mkcfg(5, 5, 5, 5, 5, 1, 1, 1);
                end
                step(1, 0, 0, 0, 0, 0, 0, 0);
                cfg_wr = 0;
            end
            for (int k = 0; k < nw; k++) step(0, 1, 0, 1, 0, 0, 1, 0);
            // R4: ready held off after the count stretches the beat; WAIT stays high (R6)
            for (int k = 0; k < stalls; k++) step(0, 0, lastb, 1, 0, 0, 0, bt_try && !bt_eff);
            if (bt_eff) step(0, 0, lastb, 1, 0, 0, 0, 1);          // R5: READY ignored under BTERM
            else if (re[r] == 1) step(0, 0, lastb, 1, 0, 0, 1, bt_try);
            else step(0, 0, lastb, 1, 0, 0, 0, bt_try);            // R4: READY ignored when disabled
            bt_prev = bt_eff;
        end
        if (gp[r] == 0) begin
            step(0, 0, 0, 0, 1, 1, 0, 1);
        end else begin
            step(0, 0, 0, 0, 1, 0, 0, 1);
            for (int k = 1; k < gp[r]; k++) step(0, 0, 0, 0, 0, 0, 0, 1);  // R10
        end
        step(0, 0, 0, 0, 0, 1, 0, 0);
        finish_check(name);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        mism = 0;
        exp_dtr = 0;
        cmp(ads_n, 1, "R1 ads_n"); cmp(wait_n, 1, "R1 wait_n"); cmp(blast_n, 1, "R1 blast_n");
        cmp(den_n, 1, "R1 den_n"); cmp(dt_r, 0, "R1 dt_r"); cmp(done, 0, "R1 done");
        cmp(req_ready, 1, "R1 req_ready");
        rst = 0;
        @(negedge clk);
        cmp(ads_n, 1, "R1 ads_n"); cmp(den_n, 1, "R1 den_n"); cmp(req_ready, 1, "R1 req_ready");
        finish_check("R1 reset state");

        // R2: program all regions while idle
        for (int r = 0; r < 4; r++) begin
            cfg_wr = 1; cfg_region = REG_W'(r);
            cfg_word = mkcfg(rf[r], rn[r], wf[r], wn[r], gp[r], re[r], be[r], pp[r]);
            @(negedge clk);
        end
        cfg_wr = 0;

        // Sweep regions 0..2 x direction x length: R3 R4 R5 R6 R7 R8 R9 R10 R11
        for (int r = 0; r < 3; r++)
            for (int wr = 0; wr < 2; wr++)
                for (int len = 1; len <= 4; len++)
                    run_txn(r, wr[0], len, 0, $sformatf("R3 sweep region=%0d wr=%0d len=%0d", r, wr, len));

        // R2: configuration write during an access is discarded
        run_txn(1, 1, 3, 1, "R2 write during access");
        run_txn(1, 1, 2, 0, "R2 config unchanged afterwards");

        // R12: pipelined back-to-back reads keep DEN low
        mism = 0;
        req_valid = 1; req_write = 0; req_len = '0; req_region = 2'd3;
        cmp(req_ready, 1, "R12 idle ready");
        @(negedge clk);
        exp_dtr = 1;
        step(1, 0, 0, 0, 0, 0, 0, 0);
        step(0, 1, 0, 1, 0, 0, 0, 0);
        step(0, 0, 1, 1, 0, 1, 0, 0);
        req_valid = 0;
        step(1, 0, 0, 1, 1, 0, 0, 0);
        step(0, 1, 0, 1, 0, 0, 0, 0);
        step(0, 0, 1, 1, 0, 1, 0, 0);
        step(0, 0, 0, 0, 1, 1, 0, 0);
        finish_check("R12 pipelined reads");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule